// File: doc/BRIEF.md
# Multiplexed Bank-Address Bus Demultiplexer

This block sits beside a processor whose eight data pins carry two things in turn. In the low half of each bus cycle they carry the top byte of a 24-bit address. In the high half they carry data. The block runs on a fast system clock and samples the processor's clock phase as an ordinary input. It captures the bank byte in a register and joins it to the sixteen dedicated address lines to form one 24-bit address.

The block also reads the processor's two validity lines as a cycle-type code, listed here as {data-valid, program-valid}: 00 is an internal operation, 01 a program address, 10 a data address and 11 an opcode fetch. A cycle is valid when the code is anything other than 00. From that code, the phase and read/write, the block produces an active-low read strobe and an active-low write strobe, plus an enable and a direction for an external data buffer. None of these is asserted in an internal-operation cycle or in the low phase. While the ready line is low, the bank register is frozen so that a stretched cycle keeps a single bank value, and the strobes repeat in each high phase of the stretched cycle.

Every output is registered, so each output reflects the inputs sampled at the previous rising system-clock edge.

Top module: `mux_bank_demux`

## Requirements
- R1: `ext_addr[15:0]` equals the dedicated address lines sampled one clock earlier, and `ext_addr[23:16]` is the bank register.
- R2: At each clock edge where the sampled phase is low and ready is high, the bank register loads the shared pins. The new value is visible one clock later. A processor in emulation mode drives 00 here, so the bank reads 00.
- R3: At each clock edge where the sampled phase is high, the bank register keeps its value, whatever data the shared pins carry.
- R4: At a clock edge where the sampled phase is low and ready is low, the bank register keeps its value.
- R5: `cycle_ok` is 1 one clock after a sample in which either validity line is high, and 0 after a sample with code 00.
- R6: One clock after a sample with code 00, both `mem_rd_n` and `mem_wr_n` are 1 and `dbuf_oe` is 0, in either phase.
- R7: `mem_rd_n` is 0 one clock after a sample with phase high, a valid code and read/write high, and is 1 otherwise.
- R8: `mem_wr_n` is 0 one clock after a sample with phase high, a valid code and read/write low, and is 1 otherwise.
- R9: `dbuf_oe` is 1 one clock after a sample with phase high and a valid code, and is 0 otherwise. `dbuf_dir` is 1 (processor to bus) after a sample with read/write low, and 0 (bus to processor) after a sample with read/write high.
- R10: `op_fetch` takes the value (data-valid AND program-valid) at the first sample in which the phase is high after a low sample, and holds that value at every other sample.
- R11: While `rst_n` is low, `mem_rd_n` and `mem_wr_n` are 1, and `dbuf_oe`, `dbuf_dir`, `cycle_ok`, `op_fetch` and `ext_addr` are all 0.
- R12: In a cycle stretched by ready, every high phase gives the same strobe and buffer outputs as the first high phase, and the bank stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor clock phase, sampled; low = bank half, high = data half |
| mux_pins | input | BANK_W (8) | Shared bank/data pins |
| addr_lo | input | ADDR_W (16) | Dedicated low address lines |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Data-address-valid line |
| vpa | input | 1 | Program-address-valid line |
| rdy | input | 1 | Ready; low stretches the bus cycle |
| ext_addr | output | BANK_W+ADDR_W (24) | Demultiplexed full address |
| cycle_ok | output | 1 | Bus cycle carries a valid address |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| dbuf_oe | output | 1 | Data buffer enable, active high |
| dbuf_dir | output | 1 | Data buffer direction, 1 = processor to bus |
| op_fetch | output | 1 | The current cycle is an opcode fetch |

## Verification
Every result of this block is due exactly one system clock after the sample that causes it. That covers the address, the bank, the cycle flag, both strobes, the buffer controls and the opcode-fetch flag. The bench drives each input set on a falling edge and predicts the outputs from that set. It compares them 1 ns after the next rising edge, so each comparison sees the outputs of exactly one sample. The bank and opcode-fetch predictions carry state from earlier samples, so the sequences cover several phases, ready-stretched cycles, and changes on the shared pins in both phases.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

   // Cycle-type code formed as {vda, vpa}.
   typedef enum logic [1:0] {
      CYC_INTERNAL = 2'b00,
      CYC_PROGRAM  = 2'b01,
      CYC_DATA     = 2'b10,
      CYC_FETCH    = 2'b11
   } cyc_kind_e;

   typedef struct packed {
      logic rd_n;
      logic wr_n;
      logic oe;
      logic dir;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, dir: 1'b0};

   function automatic logic cyc_valid(input cyc_kind_e k);
      return k != CYC_INTERNAL;
   endfunction

endpackage

// File: rtl/mbd_bank_capture.sv
module mbd_bank_capture #(
   parameter int BANK_W         = 8,
   parameter bit FREEZE_ON_WAIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              rdy,
   input  logic [BANK_W-1:0] pins,
   output logic [BANK_W-1:0] bank_q
);

   logic load;

   generate
      if (FREEZE_ON_WAIT) begin : g_freeze
         // A stretched cycle keeps its first bank byte.
         assign load = !phi2 && rdy;
      end else begin : g_follow
         // Re-latch in every low phase, ready ignored.
         logic rdy_unused;
         assign rdy_unused = rdy;
         assign load       = !phi2;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_q <= '0;
      else if (load)
         bank_q <= pins;
   end

endmodule

// File: rtl/mbd_cycle_qualify.sv
module mbd_cycle_qualify
   import mbd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    phi2,
   input  logic    vda,
   input  logic    vpa,
   input  logic    rw,
   output logic    cyc_ok,
   output strobe_t strb,
   output logic    op_fetch
);

   cyc_kind_e kind;
   logic      valid;
   logic      phi2_d;
   strobe_t   strb_nx;

   assign kind  = cyc_kind_e'({vda, vpa});
   assign valid = cyc_valid(kind);

   always_comb begin
      strb_nx      = STROBE_IDLE;
      strb_nx.dir  = !rw;
      if (phi2 && valid) begin
         strb_nx.oe   = 1'b1;
         strb_nx.rd_n = !rw;
         strb_nx.wr_n = rw;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_ok   <= 1'b0;
         strb     <= STROBE_IDLE;
         phi2_d   <= 1'b0;
         op_fetch <= 1'b0;
      end else begin
         cyc_ok <= valid;
         strb   <= strb_nx;
         phi2_d <= phi2;
         if (phi2 && !phi2_d)
            op_fetch <= (kind == CYC_FETCH);
      end
   end

endmodule

// File: rtl/mbd_addr_stage.sv
module mbd_addr_stage #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else
         addr_q <= addr_in;
   end

endmodule

// File: rtl/mux_bank_demux.sv
module mux_bank_demux
   import mbd_pkg::*;
#(
   parameter int BANK_W         = 8,
   parameter int ADDR_W         = 16,
   parameter bit FREEZE_ON_WAIT = 1'b1,
   localparam int FULL_W        = BANK_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [BANK_W-1:0] mux_pins,
   input  logic [ADDR_W-1:0] addr_lo,
   input  logic              rw,
   input  logic              vda,
   input  logic              vpa,
   input  logic              rdy,
   output logic [FULL_W-1:0] ext_addr,
   output logic              cycle_ok,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              dbuf_oe,
   output logic              dbuf_dir,
   output logic              op_fetch
);

   generate
      if (BANK_W < 1 || BANK_W > 16) begin : g_bad_bank
         $error("BANK_W must be between 1 and 16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be between 8 and 32");
      end
   endgenerate

   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] addr_q;
   strobe_t           strb;

   mbd_bank_capture #(
      .BANK_W        (BANK_W),
      .FREEZE_ON_WAIT(FREEZE_ON_WAIT)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .phi2  (phi2),
      .rdy   (rdy),
      .pins  (mux_pins),
      .bank_q(bank_q)
   );

   mbd_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_in(addr_lo),
      .addr_q (addr_q)
   );

   mbd_cycle_qualify u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .phi2    (phi2),
      .vda     (vda),
      .vpa     (vpa),
      .rw      (rw),
      .cyc_ok  (cycle_ok),
      .strb    (strb),
      .op_fetch(op_fetch)
   );

   assign ext_addr = {bank_q, addr_q};
   assign mem_rd_n = strb.rd_n;
   assign mem_wr_n = strb.wr_n;
   assign dbuf_oe  = strb.oe;
   assign dbuf_dir = strb.dir;

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker #(
   parameter int BANK_W         = 8,
   parameter int ADDR_W         = 16,
   parameter bit FREEZE_ON_WAIT = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     phi2,
   input logic [BANK_W-1:0]        mux_pins,
   input logic [ADDR_W-1:0]        addr_lo,
   input logic                     rw,
   input logic                     vda,
   input logic                     vpa,
   input logic                     rdy,
   input logic [BANK_W+ADDR_W-1:0] ext_addr,
   input logic                     cycle_ok,
   input logic                     mem_rd_n,
   input logic                     mem_wr_n,
   input logic                     dbuf_oe,
   input logic                     dbuf_dir,
   input logic                     op_fetch
);

   logic [BANK_W-1:0] bank;
   assign bank = ext_addr[BANK_W+ADDR_W-1:ADDR_W];

   AST_ADDR_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ext_addr[ADDR_W-1:0] == $past(addr_lo));                        // R1
   AST_BANK_LOADS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi2 && rdy) |=> bank == $past(mux_pins));                              // R2
   AST_BANK_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      phi2 |=> $stable(bank));                                                  // R3
   AST_CYCLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cycle_ok == $past(vda || vpa));                                  // R5
   AST_NO_STROBE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!vda && !vpa) |=> (mem_rd_n && mem_wr_n && !dbuf_oe));                  // R6
   AST_NO_STROBE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |=> (mem_rd_n && mem_wr_n && !dbuf_oe));                           // R7
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_n || mem_wr_n);                                                    // R8
   AST_OE_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dbuf_oe == (!mem_rd_n || !mem_wr_n));                                     // R9
   AST_FETCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_fetch) |-> $past(vda && vpa && phi2));                           // R10

   generate
      if (FREEZE_ON_WAIT) begin : g_wait_chk
         AST_BANK_FROZEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            (!phi2 && !rdy) |=> $stable(bank));                                 // R4
      end
   endgenerate

endmodule

bind mux_bank_demux mbd_checker #(
   .BANK_W        (BANK_W),
   .ADDR_W        (ADDR_W),
   .FREEZE_ON_WAIT(FREEZE_ON_WAIT)
) u_mbd_checker (.*);

// File: tb/mux_bank_demux_test.sv
`timescale 1ns/1ps
module mux_bank_demux_test;

   typedef struct {
      logic [23:0] addr;
      logic        ok, rd_n, wr_n, oe, dir, opf;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic [7:0]  mux_pins = '0;
   logic [15:0] addr_lo = '0;
   logic        rw = 1'b1, vda = 1'b0, vpa = 1'b0, rdy = 1'b1;
   logic [23:0] ext_addr;
   logic        cycle_ok, mem_rd_n, mem_wr_n, dbuf_oe, dbuf_dir, op_fetch;

   int   errors = 0;
   int   checks = 0;
   bit   done   = 1'b0;
   exp_t q[$];

   logic [7:0] m_bank = '0;
   logic       m_phi  = 1'b0;
   logic       m_opf  = 1'b0;

   always #2 clk = ~clk;

   mux_bank_demux uut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .mux_pins(mux_pins),
      .addr_lo(addr_lo), .rw(rw), .vda(vda), .vpa(vpa), .rdy(rdy),
      .ext_addr(ext_addr), .cycle_ok(cycle_ok), .mem_rd_n(mem_rd_n),
      .mem_wr_n(mem_wr_n), .dbuf_oe(dbuf_oe), .dbuf_dir(dbuf_dir),
      .op_fetch(op_fetch)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Driver: apply one sample and push the expected outputs for the next edge.
   task automatic drive(input logic p, input logic [7:0] pins, input logic [15:0] a,
                        input logic r, input logic dv, input logic pv, input logic rd,
                        input string tag);
      exp_t e;
      logic v;
      @(negedge clk);
      phi2 = p; mux_pins = pins; addr_lo = a; rw = r; vda = dv; vpa = pv; rdy = rd;
      v = dv | pv;
      if (!p && rd) m_bank = pins;
      if (p && !m_phi) m_opf = dv & pv;
      m_phi  = p;
      e.addr = {m_bank, a};
      e.ok   = v;
      e.rd_n = !(p && v && r);
      e.wr_n = !(p && v && !r);
      e.oe   = p && v;
      e.dir  = !r;
      e.opf  = m_opf;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // Monitor: outputs settle one clock after the sample.
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check({"R1 addr_lo ", e.tag}, {8'h0, ext_addr[15:0]}, {8'h0, e.addr[15:0]});
         check({"R2 bank ", e.tag}, {16'h0, ext_addr[23:16]}, {16'h0, e.addr[23:16]});
         check({"R5 cycle_ok ", e.tag}, {23'h0, cycle_ok}, {23'h0, e.ok});
         check({"R7 mem_rd_n ", e.tag}, {23'h0, mem_rd_n}, {23'h0, e.rd_n});
         check({"R8 mem_wr_n ", e.tag}, {23'h0, mem_wr_n}, {23'h0, e.wr_n});
         check({"R9 dbuf_oe ", e.tag}, {23'h0, dbuf_oe}, {23'h0, e.oe});
         check({"R9 dbuf_dir ", e.tag}, {23'h0, dbuf_dir}, {23'h0, e.dir});
         check({"R10 op_fetch ", e.tag}, {23'h0, op_fetch}, {23'h0, e.opf});
      end
   end

   // One bus cycle: two low samples, then two high samples.
   task automatic bus_cycle(input logic [7:0] bank, input logic [7:0] data,
                            input logic [15:0] a, input logic r,
                            input logic dv, input logic pv, input string tag);
      drive(1'b0, bank, a, r, dv, pv, 1'b1, tag);
      drive(1'b0, bank, a, r, dv, pv, 1'b1, tag);
      drive(1'b1, data, a, r, dv, pv, 1'b1, {"R3 ", tag});
      drive(1'b1, data, a, r, dv, pv, 1'b1, {"R3 ", tag});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset values while rst_n is low, with active inputs applied
      phi2 = 1'b1; vda = 1'b1; vpa = 1'b1; rw = 1'b0; mux_pins = 8'h5A; addr_lo = 16'hBEEF;
      @(negedge clk);
      check("R11 ext_addr", ext_addr, 24'h0);
      check("R11 strobes", {20'h0, mem_rd_n, mem_wr_n, dbuf_oe, dbuf_dir}, {20'h0, 4'b1100});
      check("R11 flags", {22'h0, cycle_ok, op_fetch}, 24'h0);
      phi2 = 1'b0; vda = 1'b0; vpa = 1'b0; rw = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      bus_cycle(8'h12, 8'hAA, 16'h1234, 1'b1, 1'b1, 1'b1, "opcode fetch read");
      bus_cycle(8'h7E, 8'h3C, 16'hC000, 1'b0, 1'b1, 1'b0, "data write");
      bus_cycle(8'h44, 8'h99, 16'h0101, 1'b1, 1'b0, 1'b0, "R6 internal op");
      bus_cycle(8'h45, 8'h11, 16'h8000, 1'b0, 1'b0, 1'b0, "R6 internal op write");
      bus_cycle(8'h03, 8'hF0, 16'h2222, 1'b1, 1'b0, 1'b1, "program read");
      bus_cycle(8'h00, 8'hFF, 16'hFFFC, 1'b1, 1'b1, 1'b1, "emulation bank zero");

      // R4/R12: read stretched by ready across two high phases
      drive(1'b0, 8'h05, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, "R12 wait start");
      drive(1'b0, 8'h99, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, "R4 pins change rdy low");
      drive(1'b1, 8'h21, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, "R12 high phase 1");
      drive(1'b1, 8'h21, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, "R12 high phase 1");
      drive(1'b0, 8'h66, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, "R4 second low phase");
      drive(1'b0, 8'h67, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, "R4 second low phase");
      drive(1'b1, 8'h21, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, "R12 high phase 2");
      drive(1'b1, 8'h21, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, "R12 high phase 2");

      // R12: write stretched by ready, strobe repeats
      drive(1'b0, 8'h0A, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b1, "R12 write wait");
      drive(1'b1, 8'hC3, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b0, "R12 write high 1");
      drive(1'b0, 8'hEE, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b0, "R4 write wait low");
      drive(1'b1, 8'hC3, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b1, "R12 write high 2");

      bus_cycle(8'hFE, 8'h01, 16'h0000, 1'b1, 1'b1, 1'b1, "fetch after wait");
      bus_cycle(8'h80, 8'h7F, 16'h7FFF, 1'b0, 1'b1, 1'b1, "fetch-coded write");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule